// File: doc/BRIEF.md
# Dual-Channel Serial DAC Input Front End

This block is the digital receive side of a two-channel digital-to-analog converter that takes its codes over serial links. Each channel has its own port: a bit clock, a serial data line and an active-low frame strobe. While the frame strobe is low, the channel samples one data bit on every falling edge of its bit clock, most significant bit first. After sixteen bits it holds one complete word.

A completed word reaches the channel's DAC register in one of two ways. If the channel's load input is low when the sixteenth bit arrives, the word goes into the DAC register at once. If the load input is high, the word waits in a holding register until the load input falls. One strobe can drive both load inputs, so both channels update in the same cycle. All port inputs cross into the system clock through synchronizer chains, and every edge is detected in that clock domain. Each channel emits a one-cycle update pulse whenever its DAC register is written. The code width is a parameter set to 12 or 14 bits.

Top module: `dacDualFront`

## Requirements
- R1: After reset, both DAC codes read zero and both update pulses are low.
- R2: A frame carries exactly 16 bits, sent most significant bit first. The DAC code is the low RESOLUTION bits of that word. Bit 0 is the last bit sent, and word bits 15 down to RESOLUTION are ignored.
- R3: If a channel's load input is low when the 16th falling bit-clock edge of a frame arrives, that channel's DAC code takes the new word without any load edge.
- R4: If the load input is high at the 16th edge, the DAC code does not change until the load input falls. On that falling edge the code takes the held word.
- R5: If the frame strobe returns high before 16 falling bit-clock edges, the partial word is dropped. No update happens, and a later load fall with no complete word waiting does not update the code.
- R6: Falling bit-clock edges while the frame strobe is high shift nothing and cause no update.
- R7: If a second complete word arrives while an earlier one is still waiting for a load fall, the newer word replaces the older one. A single load fall then writes only the newer word, with one pulse.
- R8: The channels are independent. Traffic on one channel never changes the other channel's code or pulse.
- R9: If both load inputs fall together while both channels hold a complete word, both codes change and both update pulses rise in the same system-clock cycle.
- R10: An update pulse lasts one system-clock cycle. It is high in exactly the cycle in which the channel's new code first appears. A code never changes without its pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must run several times faster than either bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitClk | input | 2 | Serial bit clocks, bit 0 for channel A and bit 1 for channel B; data is sampled on the falling edge |
| serData | input | 2 | Serial data lines, one per channel |
| frameN | input | 2 | Active-low frame strobes, one per channel |
| loadN | input | 2 | Active-low load inputs; held low for automatic update at frame end |
| codeA | output | RESOLUTION | DAC register contents of channel A |
| codeB | output | RESOLUTION | DAC register contents of channel B |
| updatePulse | output | 2 | One-cycle pulse per channel when its DAC register is written |

## Verification
A wrong bit counter or a stale waiting-word flag shows up at the ports as a missing, extra or mistimed update pulse. It becomes visible within about three system clocks of the sixteenth bit-clock edge or of the load fall that should have caused, or should not have caused, the update. A fault in the shift path or the holding register shows up as a wrong code in the same cycle as its pulse. So every pulse is matched, in order, against a code computed from the words sent. Channel crosstalk and dropped partial words leave no pulse to match, so the code values are also sampled at quiet points, after the offending stimulus and before the next legal transfer.

// File: rtl/dacFrontPkg.sv
package dacFrontPkg;

  // Serial word length shared by every channel.
  localparam int WORD_LEN = 16;

  // Per-channel strobes from the control logic to the datapath.
  typedef struct packed {
    logic shift;     // take one serial bit into the shift register
    logic capture;   // copy the completed word into the holding register
    logic loadNew;   // write the completed word straight into the DAC register
    logic loadHeld;  // write the holding register into the DAC register
  } chanStrobes_t;

endpackage

// File: rtl/dacSyncBits.sv
module dacSyncBits #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= {STAGES{RESET_VAL}};
    end else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) begin
        stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/dacChanCtrl.sv
module dacChanCtrl
  import dacFrontPkg::*;
#(
  parameter int WORD_BITS = WORD_LEN,
  parameter int CNT_W = $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitClkS,
  input  logic             frameNS,
  input  logic             loadNS,
  output chanStrobes_t     strobes,
  output logic [CNT_W-1:0] bitCount
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BITS - 1);

  logic clkPrev, framePrev, loadPrev;
  logic active, pending;
  logic [CNT_W-1:0] cnt;

  logic clkFall, frameFall, frameRise, loadFall;
  logic shiftHit, lastBit;

  // Edges are found in the system clock domain.
  assign clkFall   = clkPrev & ~bitClkS;
  assign frameFall = framePrev & ~frameNS;
  assign frameRise = ~framePrev & frameNS;
  assign loadFall  = loadPrev & ~loadNS;

  assign shiftHit = active & ~frameNS & clkFall;
  assign lastBit  = shiftHit && (cnt == LAST_IDX);

  always_comb begin
    strobes          = '0;
    strobes.shift    = shiftHit;
    strobes.capture  = lastBit & loadNS;
    strobes.loadNew  = lastBit & ~loadNS;
    strobes.loadHeld = loadFall & pending & ~lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev   <= 1'b1;
      framePrev <= 1'b1;
      loadPrev  <= 1'b1;
      active    <= 1'b0;
      pending   <= 1'b0;
      cnt       <= '0;
    end else begin
      clkPrev   <= bitClkS;
      framePrev <= frameNS;
      loadPrev  <= loadNS;

      if (frameFall) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (frameRise) begin
        active <= 1'b0;     // an unfinished word is dropped
        cnt    <= '0;
      end else if (lastBit) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (shiftHit) begin
        cnt <= cnt + 1'b1;
      end

      if (lastBit) begin
        pending <= loadNS;
      end else if (strobes.loadHeld) begin
        pending <= 1'b0;
      end
    end
  end

  assign bitCount = cnt;

endmodule

// File: rtl/dacChanData.sv
module dacChanData
  import dacFrontPkg::*;
#(
  parameter int RES = 14,
  parameter int WORD_BITS = WORD_LEN
) (
  input  logic           clk,
  input  logic           rstN,
  input  chanStrobes_t   strobes,
  input  logic           serBitS,
  output logic [RES-1:0] dacCode,
  output logic           updatePulse
);

  logic [WORD_BITS-1:0] shiftReg, holdReg, nextWord;
  logic [RES-1:0]       dacReg;
  logic                 pulseQ;

  assign nextWord = {shiftReg[WORD_BITS-2:0], serBitS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      holdReg  <= '0;
      dacReg   <= '0;
      pulseQ   <= 1'b0;
    end else begin
      if (strobes.shift)   shiftReg <= nextWord;
      if (strobes.capture) holdReg  <= nextWord;
      if (strobes.loadNew)       dacReg <= nextWord[RES-1:0];
      else if (strobes.loadHeld) dacReg <= holdReg[RES-1:0];
      pulseQ <= strobes.loadNew | strobes.loadHeld;
    end
  end

  assign dacCode     = dacReg;
  assign updatePulse = pulseQ;

endmodule

// File: rtl/dacDualFront.sv
module dacDualFront
  import dacFrontPkg::*;
#(
  parameter int RESOLUTION = 14,
  parameter int SYNC_STAGES = 2,
  parameter int WORD_BITS = WORD_LEN
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            bitClk,
  input  logic [1:0]            serData,
  input  logic [1:0]            frameN,
  input  logic [1:0]            loadN,
  output logic [RESOLUTION-1:0] codeA,
  output logic [RESOLUTION-1:0] codeB,
  output logic [1:0]            updatePulse
);

  localparam int NUM_CH = 2;
  localparam int CNT_W = $clog2(WORD_BITS);
  // Idle levels in order {load, frame, data, clock}.
  localparam logic [3:0] IDLE_LEVELS = 4'b1101;

  logic [NUM_CH-1:0][RESOLUTION-1:0] codeBus;
  logic [NUM_CH-1:0][CNT_W-1:0]      bitCnt;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [3:0]   syncBus;
    chanStrobes_t chanStrobes;

    dacSyncBits #(
      .WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(IDLE_LEVELS)
    ) u_sync (
      .clk(clk), .rstN(rstN),
      .asyncIn({loadN[ch], frameN[ch], serData[ch], bitClk[ch]}),
      .syncOut(syncBus)
    );

    dacChanCtrl #(.WORD_BITS(WORD_BITS), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rstN(rstN),
      .bitClkS(syncBus[0]), .frameNS(syncBus[2]), .loadNS(syncBus[3]),
      .strobes(chanStrobes), .bitCount(bitCnt[ch])
    );

    dacChanData #(.RES(RESOLUTION), .WORD_BITS(WORD_BITS)) u_data (
      .clk(clk), .rstN(rstN),
      .strobes(chanStrobes), .serBitS(syncBus[1]),
      .dacCode(codeBus[ch]), .updatePulse(updatePulse[ch])
    );
  end

  assign codeA = codeBus[0];
  assign codeB = codeBus[1];

endmodule

// File: rtl/dacDualFrontChk.sv
module dacDualFrontChk #(
  parameter int RES = 14,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       updatePulse,
  input logic [RES-1:0]   codeA,
  input logic [RES-1:0]   codeB,
  input logic [CNT_W-1:0] cntA,
  input logic [CNT_W-1:0] cntB
);

  // R10
  pulse_a_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse[0] |=> !updatePulse[0]);

  // R10
  pulse_b_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse[1] |=> !updatePulse[1]);

  // R10
  code_a_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(codeA) |-> updatePulse[0]);

  // R10
  code_b_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(codeB) |-> updatePulse[1]);

  // R2
  cnt_a_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cntA) |-> (cntA == '0) || (cntA == $past(cntA) + 1'b1));

  // R2
  cnt_b_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cntB) |-> (cntB == '0) || (cntB == $past(cntB) + 1'b1));

endmodule

bind dacDualFront dacDualFrontChk #(.RES(RESOLUTION), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .updatePulse(updatePulse),
  .codeA(codeA), .codeB(codeB), .cntA(bitCnt[0]), .cntB(bitCnt[1])
);

// File: tb/test_dacDualFront.sv
module test_dacDualFront;

  localparam int RES = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] bitClk = 2'b11;
  logic [1:0] serData = 2'b00;
  logic [1:0] frameN = 2'b11;
  logic [1:0] loadN = 2'b11;
  logic [RES-1:0] codeA, codeB;
  logic [1:0] updatePulse;

  int compared = 0;
  int mismatched = 0;
  int cycleCnt = 0;
  int pulseCyc [2] = '{-1, -1};
  logic [1:0] prevPulse = 2'b00;
  logic [RES-1:0] expQ0 [$];
  logic [RES-1:0] expQ1 [$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  dacDualFront #(.RESOLUTION(RES)) i_dacDualFront (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .serData(serData),
    .frameN(frameN), .loadN(loadN), .codeA(codeA), .codeB(codeB),
    .updatePulse(updatePulse)
  );

  function automatic logic [RES-1:0] lowBits(input logic [15:0] w);
    return w[RES-1:0];
  endfunction

  task automatic checkEq(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic expectCode(input int ch, input logic [15:0] w);
    if (ch == 0) expQ0.push_back(lowBits(w));
    else         expQ1.push_back(lowBits(w));
  endtask

  task automatic sendFrame(input int ch, input logic [15:0] w, input int nBits);
    @(negedge clk) frameN[ch] = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      serData[ch] = w[15-i];
      repeat (4) @(negedge clk);
      bitClk[ch] = 1'b0;
      repeat (4) @(negedge clk);
      bitClk[ch] = 1'b1;
    end
    repeat (4) @(negedge clk);
    frameN[ch] = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulseLoad(input logic [1:0] mask);
    @(negedge clk) loadN = loadN & ~mask;
    repeat (8) @(negedge clk);
    loadN = loadN | mask;
    repeat (6) @(negedge clk);
  endtask

  always @(posedge clk) cycleCnt++;

  // Monitor: every pulse is matched against the next expected code.
  always @(negedge clk) begin
    if (rstN) begin
      for (int ch = 0; ch < 2; ch++) begin
        if (updatePulse[ch]) begin
          pulseCyc[ch] = cycleCnt;
          if (prevPulse[ch]) checkEq("R10 pulse width", 2, 1);
          if (ch == 0) begin
            if (expQ0.size() == 0) checkEq("R5/R6/R8 unexpected pulse A", 1, 0);
            else checkEq("R2/R3/R4 code A", int'(codeA), int'(expQ0.pop_front()));
          end else begin
            if (expQ1.size() == 0) checkEq("R5/R6/R8 unexpected pulse B", 1, 0);
            else checkEq("R2/R3/R4 code B", int'(codeB), int'(expQ1.pop_front()));
          end
        end
      end
      prevPulse = updatePulse;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [RES-1:0] keepA, keepB;
    repeat (3) @(negedge clk);
    // R1 reset state
    checkEq("R1 codeA", int'(codeA), 0);
    checkEq("R1 codeB", int'(codeB), 0);
    checkEq("R1 pulses", int'(updatePulse), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R3 auto update, R2 bit order and upper bits ignored
    loadN = 2'b00;
    expectCode(0, 16'hA5C3);
    sendFrame(0, 16'hA5C3, 16);
    checkEq("R3 codeA auto", int'(codeA), int'(lowBits(16'hA5C3)));

    // R8 channel B traffic leaves A alone
    keepA = codeA;
    expectCode(1, 16'h5A3C);
    sendFrame(1, 16'h5A3C, 16);
    checkEq("R8 codeA untouched", int'(codeA), int'(keepA));
    checkEq("R3 codeB auto", int'(codeB), int'(lowBits(16'h5A3C)));

    // R2 upper bits ignored, all ones / upper-only
    expectCode(0, 16'hFFFF);
    sendFrame(0, 16'hFFFF, 16);
    expectCode(0, 16'hC000);
    sendFrame(0, 16'hC000, 16);
    checkEq("R2 upper bits dropped", int'(codeA), 0);
    // back-to-back frame
    expectCode(0, 16'h0001);
    sendFrame(0, 16'h0001, 16);

    // R4 held word waits for load fall
    loadN = 2'b11;
    repeat (4) @(negedge clk);
    keepA = codeA;
    sendFrame(0, 16'h1234, 16);
    repeat (10) @(negedge clk);
    checkEq("R4 code held before load", int'(codeA), int'(keepA));
    expectCode(0, 16'h1234);
    pulseLoad(2'b01);
    checkEq("R4 code after load", int'(codeA), int'(lowBits(16'h1234)));

    // R7 newer word replaces the waiting one
    sendFrame(0, 16'h0FFF, 16);
    sendFrame(0, 16'h3ABC, 16);
    expectCode(0, 16'h3ABC);
    pulseLoad(2'b01);
    checkEq("R7 newest word wins", int'(codeA), int'(lowBits(16'h3ABC)));

    // R5 partial frame dropped, with load low and with load high
    keepA = codeA;
    loadN = 2'b00;
    repeat (4) @(negedge clk);
    sendFrame(0, 16'h4321, 9);
    checkEq("R5 partial, load low", int'(codeA), int'(keepA));
    loadN = 2'b11;
    repeat (4) @(negedge clk);
    sendFrame(0, 16'h2222, 15);
    pulseLoad(2'b01);
    checkEq("R5 partial, load fall", int'(codeA), int'(keepA));

    // R6 bit clocks while frame high are ignored
    for (int i = 0; i < 20; i++) begin
      serData[0] = i[0];
      repeat (3) @(negedge clk);
      bitClk[0] = 1'b0;
      repeat (3) @(negedge clk);
      bitClk[0] = 1'b1;
    end
    pulseLoad(2'b01);
    checkEq("R6 idle clocks", int'(codeA), int'(keepA));
    // recovery after the dropped frames
    sendFrame(0, 16'h1357, 16);
    expectCode(0, 16'h1357);
    pulseLoad(2'b01);

    // R9 shared load
    keepB = codeB;
    sendFrame(0, 16'h2AAA, 16);
    sendFrame(1, 16'h1555, 16);
    checkEq("R4 codeB held", int'(codeB), int'(keepB));
    expectCode(0, 16'h2AAA);
    expectCode(1, 16'h1555);
    pulseLoad(2'b11);
    checkEq("R9 same cycle", pulseCyc[0], pulseCyc[1]);
    checkEq("R9 codeA", int'(codeA), int'(lowBits(16'h2AAA)));
    checkEq("R9 codeB", int'(codeB), int'(lowBits(16'h1555)));

    repeat (20) @(negedge clk);
    checkEq("R10 missing pulses A", expQ0.size(), 0);
    checkEq("R10 missing pulses B", expQ1.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule